// File: doc/BRIEF.md
# Stream Prefetch Engine Array

This block watches the demand line accesses that a cache reports and finds sequential streams in them. An access that matches no running stream is recorded as a candidate line in a small filter table. When a later access lands on the line just above or just below a candidate, the stream is confirmed and handed to one of a fixed set of prefetch engines. The engine then requests the lines ahead of the demand pointer. A new stream starts with a shallow window, and the window widens each time the program consumes a line that was prefetched.

Software can also place streams directly into engine slots. Such a stream is protected. It carries a start line, a direction and an optional line budget, and it waits until a go command starts it. Protected streams run at full depth from the first cycle. Confirmed hardware streams never displace them. A stop command removes one protected stream, and a stop-all command removes every protected stream.

Prefetch requests leave on a valid/ready stream towards the memory request queue. Once `pf_valid` is high it stays high, with `pf_line` unchanged, until a cycle with `pf_ready` high completes the transfer. No new line is chosen while the queue holds `pf_ready` low. The demand input also follows valid/ready. An access counts only in a cycle where both `dem_valid` and `dem_ready` are high, and `dem_ready` drops in any cycle that carries a command.

Top module: `stream_prefetch_array`

## Requirements
- R1: After reset `pf_valid` is low, no stream is active or armed, the filter is empty, and `dem_ready` is high whenever `cmd_valid` is low.
- R2: `dem_ready` is low in every cycle where `cmd_valid` is high. A demand presented in such a cycle is not taken and causes no prefetch.
- R3: An accepted access that matches no running stream and has no adjacent filter entry is written into the 12-entry filter. If its line is already held there, nothing is written. When the table is full, the entry allocated longest ago is overwritten.
- R4: An accepted access at line L confirms a stream when a filter entry holds L-1 (ascending) or L+1 (descending). Ascending wins when both are present. The filter entry is cleared, and the first prefetched line is L+1 or L-1.
- R5: A confirmed stream starts with a depth of 1 line ahead. Each demand that hits the next line of the stream while at least one prefetched line is outstanding doubles the depth (1, 2, 4, 8), up to a maximum of 8. The lines outstanding ahead of the demand pointer never exceed the depth.
- R6: A confirmed stream takes the lowest-index idle engine. If no engine is idle, it replaces the running unprotected stream that was allocated longest ago. If every engine is protected, the stream is dropped.
- R7: Command codes on `cmd_op` are 0 none, 1 set, 2 go, 3 stop and 4 stop-all. `cmd_id` selects the engine slot. Set loads `cmd_line` as the first line, with `cmd_dir` 0 for ascending and 1 for descending and `cmd_cnt` 0 for unlimited. The slot is armed and issues nothing until a go.
- R8: Go starts every armed slot at once at depth 8, and its first request is the programmed start line.
- R9: A protected stream with a nonzero count issues exactly that many lines and then becomes idle.
- R10: Stop removes the protected stream in slot `cmd_id` and leaves the other slots alone. It has no effect when that slot holds an unprotected stream. Stop-all removes every protected stream.
- R11: A confirmed hardware stream never replaces a protected stream, whether armed or running.
- R12: When several engines can issue, grants rotate round-robin, starting after the most recently granted engine.
- R13: While `pf_valid` is high and `pf_ready` is low, `pf_valid` stays high and `pf_line` stays unchanged. At most one line transfers per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dem_valid | input | 1 | Demand access present |
| dem_ready | output | 1 | Demand access accepted this cycle |
| dem_line | input | LINE_W | Cache-line address of the demand access |
| cmd_valid | input | 1 | Software stream command present |
| cmd_op | input | 3 | Command code (0 none, 1 set, 2 go, 3 stop, 4 stop-all) |
| cmd_id | input | clog2(N_ENG) | Engine slot addressed by set and stop |
| cmd_line | input | LINE_W | Start line for set |
| cmd_dir | input | 1 | Direction for set, 0 ascending, 1 descending |
| cmd_cnt | input | CNT_W | Line budget for set, 0 for unlimited |
| pf_valid | output | 1 | Prefetch request present |
| pf_ready | input | 1 | Memory request queue can take a request |
| pf_line | output | LINE_W | Cache-line address to prefetch |

## Verification
Every piece of state in this block shows at the ports as the set and order of lines on `pf_line`. A wrong depth register shows up as too many or too few lines within a few cycles of the demand that consumed one. A wrong demand pointer or direction shows up as a wrong line value in the very next request. An engine stuck armed, not stopped or wrongly evicted shows up as lines missing or lines arriving after a go, stop or confirming access. A rotating-pointer fault shows up as lines from different streams coming out in a different interleave. Each of these appears within a handful of cycles of the stimulus, so a scoreboard that compares the exact line sequence exposes it.

// File: rtl/spa_pkg.sv
package spa_pkg;

  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_SET      = 3'd1,
    OP_GO       = 3'd2,
    OP_STOP     = 3'd3,
    OP_STOP_ALL = 3'd4
  } cmd_op_e;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_ARMED = 2'd1,
    ENG_RUN   = 2'd2
  } eng_st_e;

endpackage

// File: rtl/spa_filter.sv
module spa_filter #(
  parameter int N      = 12,
  parameter int LINE_W = 32,
  parameter int IW     = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] look_line_i,
  input  logic              alloc_i,
  input  logic              clr_i,
  input  logic [IW-1:0]     clr_idx_i,
  output logic              up_o,
  output logic              dn_o,
  output logic [IW-1:0]     idx_o,
  output logic              exact_o
);

  logic              vld [N];
  logic [LINE_W-1:0] ent [N];
  logic [IW-1:0]     wr_ptr;

  logic [LINE_W-1:0] below, above;
  logic [IW-1:0]     up_idx, dn_idx;

  assign below = look_line_i - LINE_W'(1);
  assign above = look_line_i + LINE_W'(1);

  always_comb begin
    up_o    = 1'b0;
    dn_o    = 1'b0;
    exact_o = 1'b0;
    up_idx  = '0;
    dn_idx  = '0;
    for (int i = 0; i < N; i++) begin
      if (vld[i]) begin
        if (ent[i] == below && !up_o) begin
          up_o   = 1'b1;
          up_idx = IW'(i);
        end
        if (ent[i] == above && !dn_o) begin
          dn_o   = 1'b1;
          dn_idx = IW'(i);
        end
        if (ent[i] == look_line_i) exact_o = 1'b1;
      end
    end
    idx_o = up_o ? up_idx : dn_idx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      for (int i = 0; i < N; i++) begin
        vld[i] <= 1'b0;
        ent[i] <= '0;
      end
    end else begin
      if (clr_i) vld[clr_idx_i] <= 1'b0;
      if (alloc_i) begin
        vld[wr_ptr] <= 1'b1;
        ent[wr_ptr] <= look_line_i;
        wr_ptr      <= (wr_ptr == IW'(N - 1)) ? '0 : wr_ptr + IW'(1);
      end
    end
  end

  // R3: the write pointer always names a real slot
  a_r3_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wr_ptr) < N);

  // R3: allocation and clearing never target the table in one cycle
  a_r3_one_op: assert property (@(posedge clk) disable iff (!rst_n)
    !(alloc_i && clr_i));

endmodule

// File: rtl/spa_engine.sv
module spa_engine import spa_pkg::*; #(
  parameter int LINE_W    = 32,
  parameter int CNT_W     = 8,
  parameter int MAX_DEPTH = 8,
  parameter int DEPTH_W   = $clog2(MAX_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic [LINE_W-1:0] alloc_line_i,
  input  logic              alloc_dir_i,
  input  logic              set_i,
  input  logic [LINE_W-1:0] set_line_i,
  input  logic              set_dir_i,
  input  logic [CNT_W-1:0]  set_cnt_i,
  input  logic              go_i,
  input  logic              stop_i,
  input  logic              stop_all_i,
  input  logic              dem_fire_i,
  input  logic [LINE_W-1:0] dem_line_i,
  input  logic              grant_i,
  output logic              hit_o,
  output logic              elig_o,
  output logic [LINE_W-1:0] head_o,
  output logic              busy_o,
  output logic              run_o,
  output logic              prot_o
);

  eng_st_e            st;
  logic               prot;
  logic               dir;
  logic [LINE_W-1:0]  dptr;
  logic [DEPTH_W-1:0] ahead;
  logic [DEPTH_W-1:0] depth;
  logic               limited;
  logic [CNT_W-1:0]   remain;

  logic [LINE_W-1:0]  step;
  logic [LINE_W-1:0]  expect_line;
  logic [DEPTH_W-1:0] depth_grown;

  assign step        = LINE_W'(ahead) + LINE_W'(1);
  assign head_o      = dir ? (dptr - step) : (dptr + step);
  assign expect_line = dir ? (dptr - LINE_W'(1)) : (dptr + LINE_W'(1));
  assign depth_grown = (depth >= DEPTH_W'(MAX_DEPTH / 2)) ? DEPTH_W'(MAX_DEPTH)
                                                          : (depth << 1);

  assign hit_o  = dem_fire_i && (st == ENG_RUN) && (dem_line_i == expect_line);
  assign elig_o = (st == ENG_RUN) && (ahead < depth) && !hit_o;
  assign busy_o = (st != ENG_IDLE);
  assign run_o  = (st == ENG_RUN);
  assign prot_o = prot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ENG_IDLE;
      prot    <= 1'b0;
      dir     <= 1'b0;
      dptr    <= '0;
      ahead   <= '0;
      depth   <= DEPTH_W'(1);
      limited <= 1'b0;
      remain  <= '0;
    end else if (set_i) begin
      st      <= ENG_ARMED;
      prot    <= 1'b1;
      dir     <= set_dir_i;
      dptr    <= set_dir_i ? (set_line_i + LINE_W'(1)) : (set_line_i - LINE_W'(1));
      ahead   <= '0;
      depth   <= DEPTH_W'(MAX_DEPTH);
      limited <= (set_cnt_i != '0);
      remain  <= set_cnt_i;
    end else if (prot && (stop_i || stop_all_i)) begin
      st   <= ENG_IDLE;
      prot <= 1'b0;
    end else if (alloc_i) begin
      st      <= ENG_RUN;
      prot    <= 1'b0;
      dir     <= alloc_dir_i;
      dptr    <= alloc_line_i;
      ahead   <= '0;
      depth   <= DEPTH_W'(1);
      limited <= 1'b0;
      remain  <= '0;
    end else if (go_i && st == ENG_ARMED) begin
      st <= ENG_RUN;
    end else if (st == ENG_RUN) begin
      if (hit_o) begin
        dptr <= dem_line_i;
        if (ahead != '0) begin
          ahead <= ahead - DEPTH_W'(1);
          depth <= depth_grown;
        end
      end else if (grant_i) begin
        ahead <= ahead + DEPTH_W'(1);
        if (limited) begin
          if (remain == CNT_W'(1)) begin
            st   <= ENG_IDLE;
            prot <= 1'b0;
          end
          remain <= remain - CNT_W'(1);
        end
      end
    end
  end

  // R5: outstanding lines never exceed the current window
  a_r5_ahead_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ENG_RUN) |-> (ahead <= depth));

  // R5: the window is always a power of two no larger than the maximum
  a_r5_depth_pow2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ENG_RUN) |-> ($onehot(depth) && depth <= DEPTH_W'(MAX_DEPTH)));

  // R9: a bounded stream still running always has budget left
  a_r9_budget_left: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ENG_RUN && limited) |-> (remain != '0));

  // R7: an armed slot does not start without a go
  a_r7_armed_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ENG_ARMED && !go_i && !set_i && !stop_i && !stop_all_i && !alloc_i)
    |=> (st != ENG_RUN));

  // R11: an allocation from the detector never lands on a protected slot
  a_r11_no_alloc_prot: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |-> !prot);

endmodule

// File: rtl/spa_rr_arb.sv
module spa_rr_arb #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  input  logic          en_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] gnt_idx_o,
  output logic          gnt_any_o
);

  logic [IW-1:0] ptr;

  always_comb begin
    int k;
    gnt_o     = '0;
    gnt_idx_o = '0;
    gnt_any_o = 1'b0;
    k         = 0;
    for (int i = 0; i < N; i++) begin
      k = (int'(ptr) + i) % N;
      if (en_i && !gnt_any_o && req_i[k]) begin
        gnt_any_o = 1'b1;
        gnt_idx_o = IW'(k);
        gnt_o[k]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (gnt_any_o) begin
      ptr <= (gnt_idx_o == IW'(N - 1)) ? '0 : gnt_idx_o + IW'(1);
    end
  end

  // R12: at most one engine granted per cycle
  a_r12_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));

  // R13: no grant while the output stage cannot accept
  a_r13_no_grant_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> (gnt_o == '0));

endmodule

// File: rtl/stream_prefetch_array.sv
module stream_prefetch_array import spa_pkg::*; #(
  parameter int LINE_W    = 32,
  parameter int N_FILT    = 12,
  parameter int N_ENG     = 8,
  parameter int MAX_DEPTH = 8,
  parameter int CNT_W     = 8,
  parameter int ENG_IW    = (N_ENG > 1) ? $clog2(N_ENG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dem_valid,
  output logic              dem_ready,
  input  logic [LINE_W-1:0] dem_line,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ENG_IW-1:0] cmd_id,
  input  logic [LINE_W-1:0] cmd_line,
  input  logic              cmd_dir,
  input  logic [CNT_W-1:0]  cmd_cnt,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [LINE_W-1:0] pf_line
);

  localparam int FILT_IW = (N_FILT > 1) ? $clog2(N_FILT) : 1;
  localparam int DEPTH_W = $clog2(MAX_DEPTH) + 1;

  cmd_op_e op;
  logic    is_set, is_go, is_stop, is_stop_all;
  logic    dem_fire;

  assign op          = cmd_op_e'(cmd_op);
  assign is_set      = cmd_valid && (op == OP_SET);
  assign is_go       = cmd_valid && (op == OP_GO);
  assign is_stop     = cmd_valid && (op == OP_STOP);
  assign is_stop_all = cmd_valid && (op == OP_STOP_ALL);
  assign dem_ready   = !cmd_valid;
  assign dem_fire    = dem_valid && dem_ready;

  logic [N_ENG-1:0]  hit_v, elig_v, busy_v, run_v, prot_v;
  logic [N_ENG-1:0]  alloc_v, set_v, stop_v, gnt_v;
  logic [LINE_W-1:0] head_a [N_ENG];
  logic              any_hit;

  assign any_hit = |hit_v;

  logic               f_up, f_dn, f_exact;
  logic [FILT_IW-1:0] f_idx;
  logic               confirm, f_alloc, conf_dir;

  assign confirm  = dem_fire && !any_hit && (f_up || f_dn);
  assign f_alloc  = dem_fire && !any_hit && !f_up && !f_dn && !f_exact;
  assign conf_dir = !f_up;

  spa_filter #(.N(N_FILT), .LINE_W(LINE_W), .IW(FILT_IW)) u_filter (
    .clk         (clk),
    .rst_n       (rst_n),
    .look_line_i (dem_line),
    .alloc_i     (f_alloc),
    .clr_i       (confirm),
    .clr_idx_i   (f_idx),
    .up_o        (f_up),
    .dn_o        (f_dn),
    .idx_o       (f_idx),
    .exact_o     (f_exact)
  );

  logic [ENG_IW-1:0] age [N_ENG];
  logic              free_found, vic_found, alloc_ok;
  logic [ENG_IW-1:0] free_idx, vic_idx, vic_age, alloc_idx;
  logic              age_upd;
  logic [ENG_IW-1:0] age_idx;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    vic_found  = 1'b0;
    vic_idx    = '0;
    vic_age    = '0;
    for (int e = 0; e < N_ENG; e++) begin
      if (!busy_v[e] && !free_found) begin
        free_found = 1'b1;
        free_idx   = ENG_IW'(e);
      end
    end
    for (int e = 0; e < N_ENG; e++) begin
      if (run_v[e] && !prot_v[e] && (!vic_found || age[e] > vic_age)) begin
        vic_found = 1'b1;
        vic_idx   = ENG_IW'(e);
        vic_age   = age[e];
      end
    end
  end

  assign alloc_ok  = confirm && (free_found || vic_found);
  assign alloc_idx = free_found ? free_idx : vic_idx;
  assign age_upd   = alloc_ok || is_set;
  assign age_idx   = is_set ? cmd_id : alloc_idx;

  always_comb begin
    for (int e = 0; e < N_ENG; e++) begin
      alloc_v[e] = alloc_ok && (alloc_idx == ENG_IW'(e));
      set_v[e]   = is_set && (cmd_id == ENG_IW'(e));
      stop_v[e]  = is_stop && (cmd_id == ENG_IW'(e));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < N_ENG; e++) age[e] <= ENG_IW'(e);
    end else if (age_upd) begin
      for (int e = 0; e < N_ENG; e++) begin
        if (ENG_IW'(e) == age_idx) age[e] <= '0;
        else if (age[e] < age[age_idx]) age[e] <= age[e] + ENG_IW'(1);
      end
    end
  end

  for (genvar g = 0; g < N_ENG; g++) begin : g_eng
    spa_engine #(
      .LINE_W(LINE_W), .CNT_W(CNT_W), .MAX_DEPTH(MAX_DEPTH), .DEPTH_W(DEPTH_W)
    ) u_eng (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc_i      (alloc_v[g]),
      .alloc_line_i (dem_line),
      .alloc_dir_i  (conf_dir),
      .set_i        (set_v[g]),
      .set_line_i   (cmd_line),
      .set_dir_i    (cmd_dir),
      .set_cnt_i    (cmd_cnt),
      .go_i         (is_go),
      .stop_i       (stop_v[g]),
      .stop_all_i   (is_stop_all),
      .dem_fire_i   (dem_fire),
      .dem_line_i   (dem_line),
      .grant_i      (gnt_v[g]),
      .hit_o        (hit_v[g]),
      .elig_o       (elig_v[g]),
      .head_o       (head_a[g]),
      .busy_o       (busy_v[g]),
      .run_o        (run_v[g]),
      .prot_o       (prot_v[g])
    );
  end

  logic              arb_en, gnt_any;
  logic [ENG_IW-1:0] gnt_idx;

  assign arb_en = !pf_valid || pf_ready;

  spa_rr_arb #(.N(N_ENG), .IW(ENG_IW)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (elig_v),
    .en_i      (arb_en),
    .gnt_o     (gnt_v),
    .gnt_idx_o (gnt_idx),
    .gnt_any_o (gnt_any)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_valid <= 1'b0;
      pf_line  <= '0;
    end else if (arb_en) begin
      pf_valid <= gnt_any;
      if (gnt_any) pf_line <= head_a[gnt_idx];
    end
  end

  // R13: a stalled request is held unchanged
  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_line)));

  // R11: allocation vector never overlaps a protected slot
  a_r11_keep_prot: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_v & prot_v) == '0);

  // R2: a demand is never taken in a command cycle
  a_r2_cmd_first: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !(confirm || f_alloc || any_hit));

endmodule

// File: tb/sim_stream_prefetch_array.sv
module sim_stream_prefetch_array;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dem_valid = 1'b0;
  logic        dem_ready;
  logic [31:0] dem_line = '0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [2:0]  cmd_id = '0;
  logic [31:0] cmd_line = '0;
  logic        cmd_dir = 1'b0;
  logic [7:0]  cmd_cnt = '0;
  logic        pf_valid;
  logic        pf_ready = 1'b1;
  logic [31:0] pf_line;

  always #2 clk = ~clk;

  stream_prefetch_array u0 (
    .clk(clk), .rst_n(rst_n),
    .dem_valid(dem_valid), .dem_ready(dem_ready), .dem_line(dem_line),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_id(cmd_id),
    .cmd_line(cmd_line), .cmd_dir(cmd_dir), .cmd_cnt(cmd_cnt),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_line(pf_line)
  );

  int          checks = 0;
  int          errors = 0;
  string       cur_req = "R1";
  logic [31:0] exp_q[$];
  logic [31:0] mon_exp;

  always @(negedge clk) begin
    if (rst_n && pf_valid && pf_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL %s: unexpected prefetch line actual %0d expected none", cur_req, pf_line);
      end else begin
        mon_exp = exp_q.pop_front();
        if (pf_line !== mon_exp) begin
          errors++;
          $display("FAIL %s: prefetch line actual %0d expected %0d", cur_req, pf_line, mon_exp);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    dem_valid = 1'b0;
    cmd_valid = 1'b0;
    pf_ready = 1'b1;
    exp_q.delete();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic access(input logic [31:0] line);
    @(posedge clk); #1;
    dem_valid = 1'b1;
    dem_line = line;
    @(posedge clk); #1;
    dem_valid = 1'b0;
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [2:0] id,
                        input logic [31:0] line, input logic dir, input logic [7:0] cnt);
    @(posedge clk); #1;
    cmd_valid = 1'b1;
    cmd_op = op;
    cmd_id = id;
    cmd_line = line;
    cmd_dir = dir;
    cmd_cnt = cnt;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic drain(input string req, input int n);
    repeat (n) @(posedge clk);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [31:0] held;

  initial begin
    // R1: reset state
    do_reset();
    @(negedge clk);
    chk(pf_valid == 1'b0, "R1", pf_valid, 0);
    chk(dem_ready == 1'b1, "R1", dem_ready, 1);

    // R4 / R5: ascending detection and ramp 1,2,4,8
    cur_req = "R4";
    exp_q.push_back(32'd102);
    access(32'd100);
    access(32'd101);
    drain("R4", 20);
    cur_req = "R5";
    exp_q.push_back(32'd103); exp_q.push_back(32'd104);
    access(32'd102);
    drain("R5", 20);
    for (int i = 105; i <= 107; i++) exp_q.push_back(32'(i));
    access(32'd103);
    drain("R5", 20);
    for (int i = 108; i <= 112; i++) exp_q.push_back(32'(i));
    access(32'd104);
    drain("R5", 20);
    exp_q.push_back(32'd113);
    access(32'd105);
    drain("R5", 20);

    // R10: stop aimed at an unprotected slot has no effect; R13 stall hold
    cur_req = "R10";
    do_cmd(3'd3, 3'd0, 32'd0, 1'b0, 8'd0);
    @(posedge clk); #1 pf_ready = 1'b0;
    exp_q.push_back(32'd114);
    access(32'd106);
    repeat (4) @(posedge clk);
    @(negedge clk);
    held = pf_line;
    chk(pf_valid == 1'b1, "R13", pf_valid, 1);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(pf_valid == 1'b1 && pf_line == held, "R13", pf_line, held);
    chk(pf_line == 32'd114, "R10", pf_line, 114);
    @(posedge clk); #1 pf_ready = 1'b1;
    drain("R10", 10);

    // R2 and descending confirmation
    do_reset();
    cur_req = "R2";
    access(32'd500);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_op = 3'd0;
    dem_valid = 1'b1; dem_line = 32'd501;
    @(negedge clk);
    chk(dem_ready == 1'b0, "R2", dem_ready, 0);
    @(posedge clk); #1;
    cmd_valid = 1'b0; dem_valid = 1'b0;
    @(negedge clk);
    chk(dem_ready == 1'b1, "R1", dem_ready, 1);
    drain("R2", 20);
    cur_req = "R4";
    exp_q.push_back(32'd498);
    access(32'd499);
    drain("R4", 20);
    exp_q.push_back(32'd497); exp_q.push_back(32'd496);
    access(32'd498);
    drain("R5", 20);

    // R3: filter replacement order
    do_reset();
    cur_req = "R3";
    for (int k = 0; k <= 12; k++) access(32'(30000 + 10 * k));
    exp_q.push_back(32'd30022);
    access(32'd30021);
    drain("R3", 20);
    access(32'd30001);
    drain("R3", 20);

    // R7 / R8 / R9: protected bounded and unlimited streams
    do_reset();
    cur_req = "R7";
    do_cmd(3'd1, 3'd2, 32'd1000, 1'b0, 8'd3);
    drain("R7", 20);
    cur_req = "R9";
    exp_q.push_back(32'd1000); exp_q.push_back(32'd1001); exp_q.push_back(32'd1002);
    do_cmd(3'd2, 3'd0, 32'd0, 1'b0, 8'd0);
    drain("R9", 20);
    access(32'd1000);
    drain("R9", 20);
    cur_req = "R8";
    do_cmd(3'd1, 3'd3, 32'd2000, 1'b1, 8'd0);
    for (int i = 0; i < 8; i++) exp_q.push_back(32'(2000 - i));
    do_cmd(3'd2, 3'd0, 32'd0, 1'b0, 8'd0);
    drain("R8", 30);
    cur_req = "R10";
    do_cmd(3'd3, 3'd3, 32'd0, 1'b0, 8'd0);
    access(32'd2000);
    drain("R10", 20);

    // R12 / R6 / R11 / R10: full engine set
    do_reset();
    cur_req = "R12";
    for (int e = 0; e < 7; e++) do_cmd(3'd1, 3'(e), 32'(10000 + 100 * e), 1'b0, 8'd0);
    for (int r = 0; r < 8; r++)
      for (int e = 0; e < 7; e++) exp_q.push_back(32'(10000 + 100 * e + r));
    do_cmd(3'd2, 3'd0, 32'd0, 1'b0, 8'd0);
    drain("R12", 100);
    cur_req = "R6";
    exp_q.push_back(32'd5002);
    access(32'd5000);
    access(32'd5001);
    drain("R6", 20);
    exp_q.push_back(32'd6002);
    access(32'd6000);
    access(32'd6001);
    drain("R6", 20);
    access(32'd5002);
    drain("R6", 20);
    cur_req = "R11";
    exp_q.push_back(32'd10008);
    access(32'd10000);
    drain("R11", 20);
    cur_req = "R7";
    do_cmd(3'd1, 3'd7, 32'd20000, 1'b0, 8'd0);
    drain("R7", 20);
    cur_req = "R8";
    for (int i = 0; i < 8; i++) exp_q.push_back(32'(20000 + i));
    do_cmd(3'd2, 3'd0, 32'd0, 1'b0, 8'd0);
    drain("R8", 30);
    cur_req = "R6";
    access(32'd8000);
    access(32'd8001);
    drain("R6", 20);
    cur_req = "R10";
    do_cmd(3'd3, 3'd0, 32'd0, 1'b0, 8'd0);
    access(32'd10001);
    drain("R10", 20);
    exp_q.push_back(32'd10108);
    access(32'd10100);
    drain("R10", 20);
    do_cmd(3'd4, 3'd0, 32'd0, 1'b0, 8'd0);
    access(32'd10101);
    drain("R10", 20);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule